// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block sits beside a memory port and watches its stream of accesses. Each access arrives as a one-cycle strobe together with a 15-bit address and an active-low write enable. A command is hidden in the stream as six read accesses in a row. Five fixed lead-in addresses must come first, and the last address chooses the command. A final address of 0x0FC0 raises a single-cycle store request. A final address of 0x0C63 raises a single-cycle recall request. The block only watches: the reads that form a sequence still reach the memory as normal reads.

Any write, any read of an unexpected address, and any strobe that arrives while the downstream engine reports busy ends a partial sequence. A read of the first lead-in address is the one exception: when it breaks a sequence, it also counts as step one of a new sequence. Cycles without a strobe never change the state, so the accesses may be spread out in time. A progress value gives the number of lead-in steps matched so far, for debug.

Top module: `cmdseq_detector`

## Requirements
- R1: During and after synchronous reset, with no strobe applied, seq_step reads 0 and store_go and recall_go are low.
- R2: Read strobes (wr_n = 1, busy = 0) carrying 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F in that order advance seq_step to 1, 2, 3, 4 and 5. Each new value appears in the cycle after its strobe.
- R3: A write strobe (wr_n = 0, busy = 0) at any step returns seq_step to 0 in the next cycle and issues no command, whatever its address.
- R4: When seq_step is 5, a read strobe of 0x0FC0 makes store_go high for exactly the next cycle and returns seq_step to 0.
- R5: When seq_step is 5, a read strobe of 0x0C63 makes recall_go high for exactly the next cycle and returns seq_step to 0.
- R6: A read strobe whose address is not the one the current step expects returns seq_step to 0 and issues no command. If that address is 0x0E38, seq_step becomes 1 instead.
- R7: A strobe with busy = 1 issues no command and returns seq_step to 0, whatever its address or wr_n.
- R8: In a cycle without a strobe, seq_step keeps its value and neither command output rises.
- R9: store_go and recall_go are never high together. A command output is high only in the cycle after a strobe taken at step 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_stb | input | 1 | One-cycle strobe per chip-enable-controlled access |
| acc_addr | input | 15 | Address of the strobed access |
| wr_n | input | 1 | Write enable, active low (1 = read) |
| busy | input | 1 | Downstream engine busy; strobes are ignored while high |
| store_go | output | 1 | Single-cycle store command |
| recall_go | output | 1 | Single-cycle recall command |
| seq_step | output | 3 | Number of lead-in addresses matched (0 to 5) |

## Verification
Two functions can fall in the same cycle. One is an abort that also starts a new sequence: a wrong read of 0x0E38 at step five, or at any earlier step, must land on step 1 and not on 0. The other is a strobe that would complete a command arriving with busy high, where the busy reset must win and no pulse may appear. The bench reaches every step from 0 to 5 and applies each kind of interruption there. It then runs a long pseudo-random stream biased toward the key addresses, with busy and write mixed in, and compares both command outputs and the step value every cycle against a model built from the requirements.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int ADDR_W  = 15;
  localparam int PRE_LEN = 5;
  localparam int STEP_W  = $clog2(PRE_LEN + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef enum logic [1:0] {CMD_NONE, CMD_STORE, CMD_RECALL} cmd_e;

  localparam addr_t KEY_STORE  = 15'h0FC0;
  localparam addr_t KEY_RECALL = 15'h0C63;

  // Lead-in address expected at a given step (order is behaviour).
  function automatic addr_t lead_key(input int idx);
    case (idx)
      0: lead_key = 15'h0E38;
      1: lead_key = 15'h31C7;
      2: lead_key = 15'h03E0;
      3: lead_key = 15'h3C1F;
      4: lead_key = 15'h303F;
      default: lead_key = '0;
    endcase
  endfunction
endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match
  import cmdseq_pkg::*;
(
  input  addr_t             addr,
  input  logic [STEP_W-1:0] step,
  output logic              lead_hit,
  output logic              restart_hit,
  output cmd_e              final_cmd
);
  localparam int SLOTS = 2 ** STEP_W;

  logic [SLOTS-1:0] hit_vec;

  genvar gi;
  generate
    for (gi = 0; gi < SLOTS; gi++) begin : g_slot
      if (gi < PRE_LEN) begin : g_key
        assign hit_vec[gi] = (addr == lead_key(gi));
      end else begin : g_none
        assign hit_vec[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    lead_hit    = hit_vec[step];
    restart_hit = hit_vec[0];
    if (addr == KEY_STORE)       final_cmd = CMD_STORE;
    else if (addr == KEY_RECALL) final_cmd = CMD_RECALL;
    else                         final_cmd = CMD_NONE;
  end
endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
  import cmdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              wr_n,
  input  logic              busy,
  input  logic              lead_hit,
  input  logic              restart_hit,
  input  cmd_e              final_cmd,
  output logic [STEP_W-1:0] step_q,
  output logic              store_q,
  output logic              recall_q
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PRE_LEN);

  logic [STEP_W-1:0] step_d;
  cmd_e              issue;

  always_comb begin
    step_d = step_q;
    issue  = CMD_NONE;
    if (stb) begin
      if (busy || !wr_n) begin
        step_d = '0;
      end else if (step_q == LAST) begin
        if (final_cmd != CMD_NONE) begin
          issue  = final_cmd;
          step_d = '0;
        end else begin
          step_d = restart_hit ? STEP_W'(1) : '0;
        end
      end else if (lead_hit) begin
        step_d = step_q + STEP_W'(1);
      end else begin
        step_d = restart_hit ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q   <= '0;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      step_q   <= step_d;
      store_q  <= (issue == CMD_STORE);
      recall_q <= (issue == CMD_RECALL);
    end
  end
endmodule

// File: rtl/cmdseq_detector.sv
module cmdseq_detector
  import cmdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_stb,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              wr_n,
  input  logic              busy,
  output logic              store_go,
  output logic              recall_go,
  output logic [STEP_W-1:0] seq_step
);
  logic lead_hit;
  logic restart_hit;
  cmd_e final_cmd;

  cmdseq_match u_match (
    .addr        (acc_addr),
    .step        (seq_step),
    .lead_hit    (lead_hit),
    .restart_hit (restart_hit),
    .final_cmd   (final_cmd)
  );

  cmdseq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .stb         (acc_stb),
    .wr_n        (wr_n),
    .busy        (busy),
    .lead_hit    (lead_hit),
    .restart_hit (restart_hit),
    .final_cmd   (final_cmd),
    .step_q      (seq_step),
    .store_q     (store_go),
    .recall_q    (recall_go)
  );
endmodule

// File: rtl/cmdseq_chk.sv
module cmdseq_chk
  import cmdseq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              acc_stb,
  input logic              wr_n,
  input logic              busy,
  input logic              store_go,
  input logic              recall_go,
  input logic [STEP_W-1:0] seq_step
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PRE_LEN);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(store_go && recall_go));

  a_r9_go_source: assert property (@(posedge clk) disable iff (rst)
    (store_go || recall_go) |-> ($past(acc_stb) && $past(seq_step) == LAST && !$past(busy)));

  a_r7_busy_clears: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && busy) |=> (seq_step == '0 && !store_go && !recall_go));

  a_r3_write_clears: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && !busy && !wr_n) |=> (seq_step == '0 && !store_go && !recall_go));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_stb |=> ($stable(seq_step) && !store_go && !recall_go));

  a_r2_range: assert property (@(posedge clk) disable iff (rst)
    seq_step <= LAST);
endmodule

bind cmdseq_detector cmdseq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_stb   (acc_stb),
  .wr_n      (wr_n),
  .busy      (busy),
  .store_go  (store_go),
  .recall_go (recall_go),
  .seq_step  (seq_step)
);

// File: tb/tb_cmdseq_detector.sv
module tb_cmdseq_detector;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_stb;
  logic [14:0] acc_addr;
  logic        wr_n;
  logic        busy;
  logic        store_go;
  logic        recall_go;
  logic [2:0]  seq_step;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int exp_step = 0;
  bit exp_st   = 1'b0;
  bit exp_rc   = 1'b0;

  cmdseq_detector dut (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .acc_addr(acc_addr),
    .wr_n(wr_n), .busy(busy), .store_go(store_go), .recall_go(recall_go),
    .seq_step(seq_step)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [14:0] key(input int i);
    case (i)
      0: key = 15'h0E38;
      1: key = 15'h31C7;
      2: key = 15'h03E0;
      3: key = 15'h3C1F;
      4: key = 15'h303F;
      5: key = 15'h0FC0;
      default: key = 15'h0C63;
    endcase
  endfunction

  task automatic check(input string req);
    n_chk++;
    if (seq_step !== 3'(exp_step) || store_go !== exp_st || recall_go !== exp_rc) begin
      n_bad++;
      $display("FAIL %s: step/store/recall = %0d/%0b/%0b expected %0d/%0b/%0b",
               req, seq_step, store_go, recall_go, exp_step, exp_st, exp_rc);
    end
  endtask

  // Model from the requirements: one cycle of inputs.
  task automatic model(input bit s, input logic [14:0] a, input bit w, input bit b);
    exp_st = 1'b0;
    exp_rc = 1'b0;
    if (s) begin
      if (b || !w) exp_step = 0;
      else if (exp_step == 5 && a == 15'h0FC0) begin exp_st = 1'b1; exp_step = 0; end
      else if (exp_step == 5 && a == 15'h0C63) begin exp_rc = 1'b1; exp_step = 0; end
      else if (exp_step < 5 && a == key(exp_step)) exp_step = exp_step + 1;
      else exp_step = (a == 15'h0E38) ? 1 : 0;
    end
  endtask

  task automatic cyc(input bit s, input logic [14:0] a, input bit w, input bit b,
                     input string req);
    @(negedge clk);
    acc_stb = s; acc_addr = a; wr_n = w; busy = b;
    model(s, a, w, b);
    @(posedge clk);
    #1;
    check(req);
  endtask

  task automatic lead(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, key(i), 1'b1, 1'b0, "R2");
  endtask

  initial begin
    rst = 1'b1; acc_stb = 1'b0; acc_addr = '0; wr_n = 1'b1; busy = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    @(negedge clk);
    rst = 1'b0;
    cyc(1'b0, 15'h0E38, 1'b1, 1'b0, "R1");

    // Full store and recall, with idle gaps between strobes.
    lead(5);
    cyc(1'b0, 15'h0FC0, 1'b1, 1'b0, "R8");
    cyc(1'b1, 15'h0FC0, 1'b1, 1'b0, "R4");
    cyc(1'b0, 15'h0000, 1'b1, 1'b0, "R4");
    lead(5);
    cyc(1'b1, 15'h0C63, 1'b1, 1'b0, "R5");
    cyc(1'b0, 15'h0000, 1'b1, 1'b0, "R5");

    // Interrupt at every step with each kind of disturbance.
    for (int k = 0; k <= 5; k++) begin
      for (int v = 0; v < 5; v++) begin
        lead(k);
        case (v)
          0: cyc(1'b1, 15'h0FC0, 1'b0, 1'b0, "R3");
          1: cyc(1'b1, 15'h7FFF, 1'b1, 1'b0, "R6");
          2: cyc(1'b1, 15'h0E38, 1'b1, 1'b0, "R6");
          3: cyc(1'b1, (k == 5) ? 15'h0C63 : key(k), 1'b1, 1'b1, "R7");
          default: cyc(1'b1, 15'h0E38, 1'b0, 1'b0, "R3");
        endcase
        cyc(1'b1, 15'h1234, 1'b1, 1'b0, "R6");
      end
    end

    // Biased pseudo-random stream.
    begin
      logic [31:0] lf = 32'h1ACE_B00C;
      for (int i = 0; i < 6000; i++) begin
        logic [14:0] a;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (lf[7:4] < 4'd12) a = key(exp_step < 5 ? (lf[3] ? exp_step : 0) : (lf[2] ? 5 : 6));
        else a = lf[22:8];
        cyc(lf[12] | lf[13], a, ~(lf[14] & lf[15] & lf[16]),
            lf[17] & lf[18] & lf[19], "R9");
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule